// File: doc/BRIEF.md
# Pipelined Conditional-Sum Adder

The block adds two W-bit operands and a carry-in through a fully registered pipeline. It never lets a carry ripple. In the first stage, every bit position forms two candidate results: one that assumes the incoming carry is 0 and one that assumes it is 1. Each following stage pairs neighbouring groups into groups twice as wide. In each pair, the lower group's two candidate carries decide which candidate result of the upper group goes forward. After log2(W) such merges a single group covers the whole word, and the delayed external carry-in picks the final sum and carry-out.

There is a register after the first stage and after every merge level, so the latency is 1 + log2(W) cycles. That is 5 cycles at the default width of 16. A valid strobe and the carry-in travel with the data. One operand pair can enter on every clock edge, and results leave in the order they entered. W must be a power of two of at least 2.

Top module: `csel_adder_pipe`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0, `sum` is 0 and `carry_out` is 0.
- R2: The first stage forms two candidate sum bits and two candidate carries for every bit position: one set for an incoming carry of 0 and one set for an incoming carry of 1.
- R3: Merge level k joins groups of 2^k bits into groups of 2^(k+1) bits. In a merged group, the candidate carry for incoming carry 1 is never lower than the one for incoming carry 0. The two candidate sums always differ in the group's least significant bit.
- R4: For each accepted pair, {`carry_out`,`sum`} equals `op_a` + `op_b` + `carry_in` as an unsigned (W+1)-bit value. It appears with `out_valid` = 1 exactly 1 + log2(W) cycles after the cycle that accepted the pair (5 at W = 16).
- R5: A new pair is accepted on every cycle with `in_valid` high, including back-to-back cycles. Results come out in acceptance order with no gaps added.
- R6: Operands and carry-in on cycles with `in_valid` low are ignored. On every cycle with `out_valid` low, `sum` and `carry_out` keep the last value they held.
- R7: Carry chains that span the whole word are correct. All ones plus 1 gives `sum` 0 and `carry_out` 1. All ones plus 0 with `carry_in` 1 gives the same result. Zero plus zero with `carry_in` 1 gives `sum` 1 and `carry_out` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair and carry-in are present this cycle |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| out_valid | output | 1 | `sum` and `carry_out` hold a new result this cycle |
| sum | output | W | Low W bits of the total |
| carry_out | output | 1 | Carry out of bit W-1 |

## Verification
The assertions assume that `rst` is held high for at least one rising edge before any operation, since the hold check compares against register values loaded during reset. They also assume that `in_valid` is never unknown, because the data registers load only when it is high. The carry-ordering and bit-pairing checks hold for any operand values. The stimulus raises reset at time zero for several cycles and changes inputs only on falling edges. It drives `in_valid` to a defined level every cycle and puts random values on the operands during bubbles, so that the ignore requirement is actually exercised.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Offset of carry stage k inside the flattened carry bus.
  // Stage k holds W >> k group carries; stages are stacked from k = 0.
  function automatic int carry_off(input int w, input int k);
    return 2 * w - 2 * (w >> k);
  endfunction

  function automatic bit is_pow2(input int w);
    return (w >= 2) && ((w & (w - 1)) == 0);
  endfunction

endpackage

// File: rtl/csa_leaf.sv
// First stage: per-bit candidate sums and carries for both incoming carries.
module csa_leaf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic         cin_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic         cin_o,
  output logic [W-1:0] s0_o,
  output logic [W-1:0] s1_o,
  output logic [W-1:0] c0_o,
  output logic [W-1:0] c1_o
);

  logic [W-1:0] half_x;
  logic [W-1:0] s0_n, s1_n, c0_n, c1_n;

  // R2: modified half adder, one per bit
  always_comb begin
    half_x = a_i ^ b_i;
    s0_n   = half_x;
    s1_n   = ~half_x;
    c0_n   = a_i & b_i;
    c1_n   = a_i | b_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      cin_o   <= 1'b0;
      s0_o    <= '0;
      s1_o    <= '0;
      c0_o    <= '0;
      c1_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        cin_o <= cin_i;
        s0_o  <= s0_n;
        s1_o  <= s1_n;
        c0_o  <= c0_n;
        c1_o  <= c1_n;
      end
    end
  end

endmodule

// File: rtl/csa_merge.sv
// One intermediate merge level: groups of 2^LVL bits become 2^(LVL+1).
module csa_merge #(
  parameter int W   = 16,
  parameter int LVL = 0,
  localparam int G   = 1 << LVL,
  localparam int NGI = W >> LVL,
  localparam int NGO = NGI / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid_i,
  input  logic           cin_i,
  input  logic [W-1:0]   s0_i,
  input  logic [W-1:0]   s1_i,
  input  logic [NGI-1:0] c0_i,
  input  logic [NGI-1:0] c1_i,
  output logic           valid_o,
  output logic           cin_o,
  output logic [W-1:0]   s0_o,
  output logic [W-1:0]   s1_o,
  output logic [NGO-1:0] c0_o,
  output logic [NGO-1:0] c1_o
);

  logic [W-1:0]   m0, m1;
  logic [NGO-1:0] mc0, mc1;

  // R3: lower-group carry chooses the upper group's candidate
  for (genvar g = 0; g < NGO; g++) begin : g_pair
    localparam int LO = 2 * g * G;
    localparam int HI = (2 * g + 1) * G;
    assign m0[LO +: G] = s0_i[LO +: G];
    assign m1[LO +: G] = s1_i[LO +: G];
    assign m0[HI +: G] = c0_i[2*g] ? s1_i[HI +: G] : s0_i[HI +: G];
    assign m1[HI +: G] = c1_i[2*g] ? s1_i[HI +: G] : s0_i[HI +: G];
    assign mc0[g]      = c0_i[2*g] ? c1_i[2*g+1] : c0_i[2*g+1];
    assign mc1[g]      = c1_i[2*g] ? c1_i[2*g+1] : c0_i[2*g+1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      cin_o   <= 1'b0;
      s0_o    <= '0;
      s1_o    <= '0;
      c0_o    <= '0;
      c1_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        cin_o <= cin_i;
        s0_o  <= m0;
        s1_o  <= m1;
        c0_o  <= mc0;
        c1_o  <= mc1;
      end
    end
  end

  // R3
  merge_carry_order_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((c0_o & ~c1_o) == '0));

  for (genvar g = 0; g < NGO; g++) begin : g_lsb_chk
    // R3
    merge_lsb_pair_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (s0_o[g*2*G] != s1_o[g*2*G]));
  end

endmodule

// File: rtl/csa_final.sv
// Last merge level: joins the two halves and applies the real carry-in.
module csa_final #(
  parameter int W = 16,
  localparam int H = W / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic         cin_i,
  input  logic [W-1:0] s0_i,
  input  logic [W-1:0] s1_i,
  input  logic [1:0]   c0_i,
  input  logic [1:0]   c1_i,
  output logic         valid_o,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W-1:0] m0, m1, sum_n;
  logic         mc0, mc1, cout_n;

  always_comb begin
    m0[H-1:0] = s0_i[H-1:0];
    m1[H-1:0] = s1_i[H-1:0];
    m0[W-1:H] = c0_i[0] ? s1_i[W-1:H] : s0_i[W-1:H];
    m1[W-1:H] = c1_i[0] ? s1_i[W-1:H] : s0_i[W-1:H];
    mc0       = c0_i[0] ? c1_i[1] : c0_i[1];
    mc1       = c1_i[0] ? c1_i[1] : c0_i[1];
    sum_n     = cin_i ? m1 : m0;
    cout_n    = cin_i ? mc1 : mc0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      cout_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sum_o  <= sum_n;
        cout_o <= cout_n;
      end
    end
  end

  // R6
  final_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(sum_o) && $stable(cout_o)));

endmodule

// File: rtl/csel_adder_pipe.sv
module csel_adder_pipe #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] sum,
  output logic         carry_out
);

  localparam int LEVELS = $clog2(W);
  localparam int CBITS  = 2 * W - 2;

  logic [W-1:0]     s0_b [LEVELS];
  logic [W-1:0]     s1_b [LEVELS];
  logic [CBITS-1:0] c0_b, c1_b;
  logic [LEVELS-1:0] vld_b, cin_b;

  csa_leaf #(.W(W)) u_leaf (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid),
    .cin_i   (carry_in),
    .a_i     (op_a),
    .b_i     (op_b),
    .valid_o (vld_b[0]),
    .cin_o   (cin_b[0]),
    .s0_o    (s0_b[0]),
    .s1_o    (s1_b[0]),
    .c0_o    (c0_b[W-1:0]),
    .c1_o    (c1_b[W-1:0])
  );

  for (genvar l = 0; l < LEVELS - 1; l++) begin : g_level
    localparam int NGI  = W >> l;
    localparam int NGO  = NGI / 2;
    localparam int OFFI = csa_pkg::carry_off(W, l);
    localparam int OFFO = csa_pkg::carry_off(W, l + 1);
    csa_merge #(.W(W), .LVL(l)) u_merge (
      .clk     (clk),
      .rst     (rst),
      .valid_i (vld_b[l]),
      .cin_i   (cin_b[l]),
      .s0_i    (s0_b[l]),
      .s1_i    (s1_b[l]),
      .c0_i    (c0_b[OFFI +: NGI]),
      .c1_i    (c1_b[OFFI +: NGI]),
      .valid_o (vld_b[l+1]),
      .cin_o   (cin_b[l+1]),
      .s0_o    (s0_b[l+1]),
      .s1_o    (s1_b[l+1]),
      .c0_o    (c0_b[OFFO +: NGO]),
      .c1_o    (c1_b[OFFO +: NGO])
    );
  end

  localparam int OFFL = csa_pkg::carry_off(W, LEVELS - 1);

  csa_final #(.W(W)) u_final (
    .clk     (clk),
    .rst     (rst),
    .valid_i (vld_b[LEVELS-1]),
    .cin_i   (cin_b[LEVELS-1]),
    .s0_i    (s0_b[LEVELS-1]),
    .s1_i    (s1_b[LEVELS-1]),
    .c0_i    (c0_b[OFFL +: 2]),
    .c1_i    (c1_b[OFFL +: 2]),
    .valid_o (out_valid),
    .sum_o   (sum),
    .cout_o  (carry_out)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && sum == '0 && !carry_out));

endmodule

// File: tb/test_csel_adder_pipe.sv
module test_csel_adder_pipe;
  localparam int W          = 16;
  localparam int LAT        = 1 + $clog2(W);
  localparam int CLK_PERIOD = 10;
  localparam int QD         = 256;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         carry_in = 1'b0;
  logic         out_valid;
  logic [W-1:0] sum;
  logic         carry_out;

  csel_adder_pipe #(.W(W)) i_csel_adder_pipe (
    .clk, .rst, .in_valid, .op_a, .op_b, .carry_in,
    .out_valid, .sum, .carry_out
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W:0] exp_q [QD];
  int         iss_q [QD];
  string      tag_q [QD];
  int         wr = 0, rd = 0;
  logic [W:0] last_out = '0;

  task automatic chk(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Result monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        if (rd == wr) begin
          chk(1'b0, "R5 unexpected result", {carry_out, sum}, '0);
        end else begin
          chk({carry_out, sum} == exp_q[rd % QD], tag_q[rd % QD], {carry_out, sum}, exp_q[rd % QD]);
          chk(cyc - iss_q[rd % QD] == LAT, "R4 latency", (W+1)'(cyc - iss_q[rd % QD]), (W+1)'(LAT));
          rd++;
        end
        last_out = {carry_out, sum};
      end else begin
        chk({carry_out, sum} == last_out, "R6 hold while out_valid low", {carry_out, sum}, last_out);
      end
    end
  end

  task automatic issue(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input string tag);
    @(negedge clk);
    in_valid = v;
    op_a     = a;
    op_b     = b;
    carry_in = ci;
    if (v) begin
      exp_q[wr % QD] = {1'b0, a} + {1'b0, b} + (W+1)'(ci);
      iss_q[wr % QD] = cyc;
      tag_q[wr % QD] = tag;
      wr++;
    end
  endtask

  task automatic idle_bubble();
    issue(1'b0, W'($urandom), W'($urandom), 1'($urandom), "");
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < LAT + 2; i++) idle_bubble();
    chk(rd == wr, req, (W+1)'(rd), (W+1)'(wr));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    op_a = '1; op_b = '1; carry_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && sum == '0 && !carry_out, "R1 during reset", {carry_out, sum}, '0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid after reset", (W+1)'(out_valid), '0);
    chk({carry_out, sum} == '0, "R1 outputs after reset", {carry_out, sum}, '0);
  endtask

  task automatic t_corners();
    issue(1, '1, W'(1), 1'b0, "R7 all ones plus one");
    idle_bubble();
    issue(1, '1, '0, 1'b1, "R7 all ones plus carry-in");
    issue(1, '0, '0, 1'b1, "R7 zero plus carry-in");
    issue(1, '0, '0, 1'b0, "R4 zero plus zero");
    issue(1, {(W/2){2'b10}}, {(W/2){2'b01}}, 1'b1, "R7 alternating plus carry-in");
    issue(1, {(W/2){2'b01}}, {(W/2){2'b01}}, 1'b1, "R2 alternating doubled");
    issue(1, '1, '1, 1'b1, "R3 all ones both");
    issue(1, {1'b1, {(W-1){1'b0}}}, {1'b1, {(W-1){1'b0}}}, 1'b0, "R3 top bit carry");
    issue(1, {{(W/2){1'b0}}, {(W/2){1'b1}}}, W'(1), 1'b0, "R3 half-word carry");
    drain("R4 corners drained");
  endtask

  task automatic t_random();
    for (int i = 0; i < 60; i++) begin
      issue(1, W'($urandom), W'($urandom), 1'($urandom), "R4 random operands");
      if (i % 3 == 0) idle_bubble();
    end
    drain("R4 random drained");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 40; i++)
      issue(1, W'($urandom), W'(i * 977), 1'(i), "R5 back-to-back order");
    drain("R5 stream drained");
  endtask

  task automatic t_bubbles();
    issue(1, W'(16'h1234), W'(16'h0F0F), 1'b1, "R6 before bubbles");
    for (int i = 0; i < 12; i++) idle_bubble();
    chk(rd == wr, "R6 no output from ignored inputs", (W+1)'(rd), (W+1)'(wr));
    issue(1, W'(16'h8000), W'(16'h8000), 1'b1, "R6 after bubbles");
    drain("R6 bubbles drained");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_stream();
    t_bubbles();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule